// File: doc/BRIEF.md
# Serial Configuration Master Controller

This block is the master end of a four-wire link to an external serial flash that holds a configuration bitstream. It is used when a device loads itself at power-up. When the reconfigure request is released, the block pulls chip select low and starts a divided serial clock. It sends a read opcode and a 24-bit start address, most significant bit first. It then collects the returned bits, most significant bit first, into bytes and hands each byte to a downstream loader with a one-cycle strobe.

The block also supervises the loader's done flag. A done flag that arrives while bits are still being fetched is an early completion. A done flag that has not arrived within a grace window after the last bit is a late completion. In either case the block pulses its status output low, releases the flash and repeats the whole load. A done flag inside the window starts an initialization delay, after which user mode is signalled. Holding the reconfigure request low returns the block to idle from any state.

Top module: `cfgm_master`

## Requirements
- R1: While reset is asserted and after it is released with the request held low, chip select is high, the serial clock is low, status is high, and user mode and the byte strobe are low.
- R2: While `reconfig_ni` is low, chip select stays high and the serial clock does not toggle.
- R3: Each access shifts out 32 command bits on `mosi_o`, most significant bit first: the opcode 0x03 in bits 31..24, then `start_addr_i` in bits 23..0. Each bit is stable at the rising serial clock edge that samples it.
- R4: Chip select falls `CLK_HALF` clock cycles before the first rising serial clock edge. It stays low through the whole access and is high once the last data bit has been captured.
- R5: The serial clock idles low and has a period of 2*`CLK_HALF` system clock cycles.
- R6: Data bit j, which the flash drives after falling edge 31+j, is captured at falling edge 32+j. Bits are packed most significant bit first, so `byte_o` carries the flash bytes from the start address upward. The address wraps at 0xFFFFFF, and one access yields `bit_len_i`/8 bytes.
- R7: `byte_valid_o` is high for exactly one cycle per byte.
- R8: If `done_i` is high during an access, `status_no` goes low for exactly `ERR_CYC` cycles with chip select high. The load then restarts from the read command.
- R9: If `done_i` is still low `GRACE_CYC` cycles after the last bit, the same error pulse and restart occur. The status output stays high for the first `GRACE_CYC`-1 cycles of the window.
- R10: If `done_i` is seen within the window, `user_mode_o` rises exactly `INIT_CYC` cycles after the sampling edge and stays high, with chip select high.
- R11: Pulling `reconfig_ni` low in user mode clears `user_mode_o` on the next cycle. Releasing it starts a fresh load from the current start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reconfig_ni | input | 1 | Active-low reconfigure request; low holds the block idle |
| start_addr_i | input | ADDR_W | Flash byte address to start reading from |
| bit_len_i | input | LEN_W | Expected bitstream length in bits |
| done_i | input | 1 | Completion flag from the loader |
| miso_i | input | 1 | Serial data returned by the flash |
| cs_no | output | 1 | Active-low flash chip select |
| sclk_o | output | 1 | Serial clock to the flash |
| mosi_o | output | 1 | Serial command and address line |
| byte_o | output | 8 | Assembled data byte |
| byte_valid_o | output | 1 | One-cycle strobe for `byte_o` |
| status_no | output | 1 | Active-low error pulse |
| user_mode_o | output | 1 | High once configuration has completed |

## Verification
The load sequence is driven with four done-flag patterns. The flag rises after the first byte (early), never rises (late), rises right after the last byte (timely), and is withdrawn by a reconfigure request in user mode. Early and late are told apart by when the error pulse starts: during the access, or exactly at the end of the grace window. A timely flag is told apart from both by the exact user-mode delay. Two start addresses are used, one in mid-range and one four bytes below the top of the 24-bit space. Together they show that the address field is shifted most significant bit first and that the byte stream follows the flash contents across the wrap.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  localparam int          BYTE_W = 8;
  localparam logic [7:0]  RD_OP  = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CHK,
    ST_ERR,
    ST_INIT,
    ST_USER
  } cfg_state_e;
endpackage

// File: rtl/cfgm_sclk_gen.sv
module cfgm_sclk_gen #(
  parameter int CLK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == CW'(CLK_HALF - 1));
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgm_deser.sv
module cfgm_deser import cfgm_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int BW = $clog2(BYTE_W);

  logic [BW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic [BYTE_W-1:0] sr_nxt;

  assign sr_nxt = {sr_q[BYTE_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else if (cap_i) begin
      sr_q    <= sr_nxt;
      cnt_q   <= cnt_q + 1'b1;
      valid_o <= (cnt_q == BW'(BYTE_W - 1));
      if (cnt_q == BW'(BYTE_W - 1)) byte_o <= sr_nxt;
    end else begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgm_master.sv
module cfgm_master import cfgm_pkg::*; #(
  parameter int CLK_HALF  = 2,
  parameter int ERR_CYC   = 8,
  parameter int INIT_CYC  = 16,
  parameter int GRACE_CYC = 32,
  parameter int LEN_W     = 32,
  parameter int ADDR_W    = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reconfig_ni,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  bit_len_i,
  input  logic              done_i,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              status_no,
  output logic              user_mode_o
);
  localparam int CMD_W = BYTE_W + ADDR_W;
  localparam int CNT_W = LEN_W + 1;
  localparam int T_A   = (ERR_CYC > INIT_CYC) ? ERR_CYC : INIT_CYC;
  localparam int T_MAX = (T_A > GRACE_CYC) ? T_A : GRACE_CYC;
  localparam int TMR_W = $clog2(T_MAX + 1);

  cfg_state_e       state_q;
  logic [CNT_W-1:0] fall_cnt_q;
  logic [CNT_W-1:0] total_bits;
  logic [CMD_W-1:0] cmd_q;
  logic [TMR_W-1:0] tmr_q;
  logic             shifting;
  logic             sclk_raw, rise_tick, fall_tick;
  logic             last_fall, cap;

  assign shifting   = (state_q == ST_SHIFT);
  assign total_bits = CNT_W'(bit_len_i) + CNT_W'(CMD_W);
  assign last_fall  = fall_tick && (fall_cnt_q == total_bits - 1'b1);
  assign cap        = fall_tick && (fall_cnt_q >= CNT_W'(CMD_W));

  cfgm_sclk_gen #(.CLK_HALF(CLK_HALF)) i_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (shifting),
    .sclk_o (sclk_raw),
    .rise_o (rise_tick),
    .fall_o (fall_tick)
  );

  cfgm_deser i_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_IDLE),
    .cap_i   (cap),
    .bit_i   (miso_i),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      fall_cnt_q <= '0;
      cmd_q      <= '0;
      tmr_q      <= '0;
    end else if (!reconfig_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q    <= ST_SHIFT;
          fall_cnt_q <= '0;
          cmd_q      <= {RD_OP, start_addr_i};
        end
        ST_SHIFT: begin
          if (done_i) begin
            // completion before the stream ended
            state_q <= ST_ERR;
            tmr_q   <= '0;
          end else if (fall_tick) begin
            fall_cnt_q <= fall_cnt_q + 1'b1;
            cmd_q      <= {cmd_q[CMD_W-2:0], 1'b0};
            if (last_fall) begin
              state_q <= ST_CHK;
              tmr_q   <= '0;
            end
          end
        end
        ST_CHK: begin
          if (done_i) begin
            state_q <= ST_INIT;
            tmr_q   <= '0;
          end else if (tmr_q == TMR_W'(GRACE_CYC - 1)) begin
            state_q <= ST_ERR;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_ERR: begin
          if (tmr_q == TMR_W'(ERR_CYC - 1)) state_q <= ST_IDLE;
          else                              tmr_q   <= tmr_q + 1'b1;
        end
        ST_INIT: begin
          if (tmr_q == TMR_W'(INIT_CYC - 1)) state_q <= ST_USER;
          else                               tmr_q   <= tmr_q + 1'b1;
        end
        ST_USER: state_q <= ST_USER;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no       = !shifting;
  assign sclk_o      = sclk_raw && shifting;
  assign mosi_o      = shifting && cmd_q[CMD_W-1];
  assign status_no   = (state_q != ST_ERR);
  assign user_mode_o = (state_q == ST_USER);

  logic unused_rise;
  assign unused_rise = rise_tick;
endmodule

// File: rtl/cfgm_master_chk.sv
module cfgm_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic reconfig_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic byte_valid_o,
  input logic status_no,
  input logic user_mode_o
);
  // R4
  cs_hi_no_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reconfig_ni |=> cs_no);

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  // R8
  err_cs_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_no |-> cs_no && !user_mode_o);

  // R10
  user_cs_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode_o |-> cs_no && status_no);

  // R11
  reconfig_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reconfig_ni |=> !user_mode_o);
endmodule

bind cfgm_master cfgm_master_chk i_cfgm_master_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reconfig_ni  (reconfig_ni),
  .cs_no        (cs_no),
  .sclk_o       (sclk_o),
  .byte_valid_o (byte_valid_o),
  .status_no    (status_no),
  .user_mode_o  (user_mode_o)
);

// File: tb/test_cfgm_master.sv
`timescale 1ns/1ps
module test_cfgm_master;
  localparam int CLK_HALF  = 2;
  localparam int ERR_CYC   = 8;
  localparam int INIT_CYC  = 16;
  localparam int GRACE_CYC = 32;
  localparam int NBYTES    = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reconfig_ni = 1'b0;
  logic [23:0] start_addr = 24'h0;
  logic [31:0] bit_len = 32'd64;
  logic        done = 1'b0;
  logic        miso = 1'b0;
  logic        cs_no, sclk_o, mosi_o, byte_valid_o, status_no, user_mode_o;
  logic [7:0]  byte_o;

  int checks = 0;
  int bad = 0;
  logic [7:0] rx [NBYTES];

  int          txn_cnt = 0;
  logic [31:0] last_cmd = '0;
  realtime     t_csf, t_r0, t_r1;

  always #2 clk = ~clk;

  cfgm_master #(
    .CLK_HALF(CLK_HALF), .ERR_CYC(ERR_CYC), .INIT_CYC(INIT_CYC),
    .GRACE_CYC(GRACE_CYC), .LEN_W(32), .ADDR_W(24)
  ) i_cfgm_master (
    .clk_i(clk), .rst_ni(rst_ni), .reconfig_ni(reconfig_ni),
    .start_addr_i(start_addr), .bit_len_i(bit_len), .done_i(done),
    .miso_i(miso), .cs_no(cs_no), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .status_no(status_no),
    .user_mode_o(user_mode_o)
  );

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return a[7:0] ^ {a[3:0], a[7:4]} ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // flash model
  initial begin
    logic [31:0] cmd;
    logic [23:0] addr;
    int n, bi;
    bit data_on;
    forever begin
      @(negedge cs_no);
      t_csf = $realtime; cmd = '0; n = 0; bi = 0; data_on = 0;
      forever begin
        @(sclk_o or cs_no);
        #1;
        if (cs_no) break;
        if (sclk_o) begin
          if (n < 32) begin
            cmd = {cmd[30:0], mosi_o};
            n++;
            if (n == 1) t_r0 = $realtime - 1;
            if (n == 2) t_r1 = $realtime - 1;
            if (n == 32) begin
              txn_cnt++; last_cmd = cmd; addr = cmd[23:0]; data_on = 1;
            end
          end
        end else if (data_on) begin
          miso = fmem(addr)[7-bi];
          bi++;
          if (bi == 8) begin bi = 0; addr = addr + 1'b1; end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic collect(input int n);
    int k = 0;
    bit prev = 0;
    int dbl = 0;
    while (k < n) begin
      @(negedge clk);
      if (byte_valid_o) begin
        if (prev) dbl++;
        rx[k] = byte_o;
        k++;
      end
      prev = byte_valid_o;
    end
    chk(dbl == 0, "R7", "strobe longer than one cycle", dbl, 0);
  endtask

  task automatic check_bytes(input logic [23:0] a, input int n);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      logic [23:0] ai = a + 24'(i);
      if (rx[i] !== fmem(ai)) begin
        errs++;
        $display("FAIL R6 byte %0d: actual=%0h expected=%0h", i, rx[i], fmem(ai));
      end
    end
    checks++;
    if (errs != 0) bad++;
  endtask

  task automatic t_reset;
    rst_ni = 0; reconfig_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_no && !sclk_o && status_no && !user_mode_o && !byte_valid_o,
        "R1", "outputs in reset", {cs_no, sclk_o, status_no, user_mode_o, byte_valid_o}, 5'b10100);
    rst_ni = 1;
    @(negedge clk);
    chk(cs_no && !sclk_o && status_no && !user_mode_o, "R1", "outputs after reset",
        {cs_no, sclk_o, status_no, user_mode_o}, 4'b1010);
  endtask

  task automatic t_idle_hold;
    int viol = 0;
    repeat (40) begin
      @(negedge clk);
      if (!cs_no || sclk_o) viol++;
    end
    chk(viol == 0, "R2", "activity while request low", viol, 0);
    chk(txn_cnt == 0, "R2", "flash accesses while request low", txn_cnt, 0);
  endtask

  task automatic t_early_late_good;
    int base, lows;
    start_addr = 24'h12345C; bit_len = 32'd64; done = 0;
    base = txn_cnt;
    @(negedge clk); reconfig_ni = 1;
    collect(1);
    chk(rx[0] == fmem(24'h12345C), "R6", "first byte", rx[0], fmem(24'h12345C));
    chk(last_cmd == {8'h03, 24'h12345C}, "R3", "command word", last_cmd, {8'h03, 24'h12345C});
    chk((t_r0 - t_csf) == CLK_HALF * 4.0, "R4", "select lead ns", longint'(t_r0 - t_csf), CLK_HALF * 4);
    chk((t_r1 - t_r0) == CLK_HALF * 8.0, "R5", "sclk period ns", longint'(t_r1 - t_r0), CLK_HALF * 8);
    // early done
    done = 1;
    @(negedge clk);
    chk(!status_no && cs_no, "R8", "error on early done", {status_no, cs_no}, 2'b01);
    done = 0;
    lows = 1;
    forever begin
      @(negedge clk);
      if (status_no) break;
      lows++;
    end
    chk(lows == ERR_CYC, "R8", "error pulse length", lows, ERR_CYC);
    collect(NBYTES);
    check_bytes(24'h12345C, NBYTES);
    chk(txn_cnt == base + 2, "R8", "restarted access count", txn_cnt, base + 2);
    chk(cs_no, "R4", "select high after last bit", cs_no, 1);
    // late done
    repeat (GRACE_CYC - 1) @(posedge clk);
    @(negedge clk);
    chk(status_no, "R9", "status before window end", status_no, 1);
    @(posedge clk); @(negedge clk);
    chk(!status_no, "R9", "status at window end", status_no, 0);
    collect(NBYTES);
    check_bytes(24'h12345C, NBYTES);
    chk(txn_cnt == base + 3, "R9", "restart after late done", txn_cnt, base + 3);
    // timely done
    done = 1;
    repeat (INIT_CYC) @(posedge clk);
    @(negedge clk);
    chk(!user_mode_o, "R10", "user mode before init end", user_mode_o, 0);
    @(posedge clk); @(negedge clk);
    chk(user_mode_o && cs_no, "R10", "user mode after init", {user_mode_o, cs_no}, 2'b11);
    repeat (10) @(negedge clk);
    chk(user_mode_o && txn_cnt == base + 3, "R10", "user mode held", user_mode_o, 1);
  endtask

  task automatic t_reconfig;
    int viol = 0;
    int w = 0;
    int base;
    reconfig_ni = 0; done = 0;
    @(negedge clk);
    chk(!user_mode_o && cs_no, "R11", "user mode cleared", user_mode_o, 0);
    repeat (20) begin
      @(negedge clk);
      if (!cs_no || sclk_o) viol++;
    end
    chk(viol == 0, "R2", "idle during request", viol, 0);
    base = txn_cnt;
    start_addr = 24'hFFFFFC;
    reconfig_ni = 1;
    collect(NBYTES);
    chk(last_cmd == {8'h03, 24'hFFFFFC}, "R3", "command with top address", last_cmd, {8'h03, 24'hFFFFFC});
    check_bytes(24'hFFFFFC, NBYTES);
    chk(txn_cnt == base + 1, "R11", "fresh load count", txn_cnt, base + 1);
    done = 1;
    while (!user_mode_o && w < 40) begin @(negedge clk); w++; end
    chk(user_mode_o, "R11", "user mode after reload", user_mode_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_hold();
    t_early_late_good();
    t_reconfig();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule